// File: doc/BRIEF.md
# Streaming FIR Multiply-Accumulate Engine with Circular Sample Store

This block filters a stream of signed fixed-point samples with an N-tap FIR filter. It uses one multiplier and one adder, shared across the taps. When a sample is accepted it is written into a circular store that keeps the N most recent samples. A loop sequencer then runs one multiply-accumulate per cycle for N cycles. During that loop, one pointer walks the coefficient table upward and a second pointer walks the sample store downward. Both pointers wrap modulo N.

Each product is rescaled by an arithmetic right shift so that the binary point is kept. The accumulator holds four extra fraction bits and enough guard bits that no sum of N products can overflow. At the end of the loop the total is rounded to the sample format and clamped to it, then presented as one output word. Coefficients are written through a simple indexed write port between samples.

Top module: `fir_mac_ring`

## Requirements
- R1: For every accepted sample x_j, the output equals the sum over i = 0..TAPS-1 of trunc(x_{j-i}·a_i), rounded and clamped as in R5 to R7. Here trunc(p) is floor(p / 2^11), taken on the full 32-bit signed product, and x_{j-i} is the sample accepted i samples earlier.
- R2: After an accepted sample, s_ready is low for exactly TAPS cycles. A sample is accepted only when s_valid and s_ready are both high at a clock edge.
- R3: y_valid is a single-cycle pulse. It is high on the TAPS-th clock edge after the edge that accepted the sample, and at no other time.
- R4: The sample store keeps only the TAPS most recent samples. The sample accepted TAPS positions before the newest one has no effect on the output.
- R5: If the rounded result exceeds +32767, y_data is 16'h7FFF.
- R6: If the rounded result is below -32768, y_data is 16'h8000.
- R7: Rounding adds 8 to the accumulator (4 fraction bits below the output LSB) and then shifts it arithmetically right by 4. A half step therefore rounds toward plus infinity.
- R8: A coefficient write (coef_we high, with coef_idx as the tap number) while s_ready is low is ignored. It changes neither the output in progress nor the later outputs.
- R9: After reset, s_ready is 1, y_valid is 0 and y_data is 0. All stored samples and coefficients are zero.
- R10: y_data changes only on the edge that raises y_valid, and it holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample offered |
| s_ready | output | 1 | Engine idle; a sample can be taken |
| s_data | input | 16 | Signed Q1.15 input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 3 | Tap number written |
| coef_data | input | 16 | Signed Q1.15 coefficient |
| y_valid | output | 1 | One-cycle pulse: filtered result present |
| y_data | output | 16 | Signed Q1.15 filtered result |

## Verification
The bound checker covers the handshake timing on every cycle. It checks that s_ready stays low for the whole loop, that y_valid comes exactly TAPS edges after acceptance and lasts one cycle, and that y_data holds between pulses. Only the bench scenarios can show the arithmetic. These scenarios cover the tap-by-tap alignment of samples and coefficients, the eviction of the oldest sample when the store wraps, truncation and rounding at the half-step boundaries, clamping in both directions, and that coefficient writes during a loop are ignored. For each of these, the bench computes the value from its own history of samples and coefficients.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fir_state_e;
endpackage

// File: rtl/fir_mod_ptr.sv
// Modulo-N pointer: load, or step by one in the chosen direction with wrap.
module fir_mod_ptr #(
  parameter int N  = 8,
  parameter bit UP = 1'b1,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [AW-1:0] adv;
  logic [AW-1:0] ptr_nxt;

  generate
    if (UP) begin : g_up
      always_comb adv = (ptr == LAST) ? '0 : ptr + 1'b1;
    end else begin : g_down
      always_comb adv = (ptr == '0) ? LAST : ptr - 1'b1;
    end
  endgenerate

  always_comb begin
    ptr_nxt = ptr;
    if (load)      ptr_nxt = load_val;
    else if (step) ptr_nxt = adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/fir_mac_unit.sv
// Multiply, rescale by arithmetic shift, accumulate into guarded register.
module fir_mac_unit #(
  parameter int DW    = 16,
  parameter int SHIFT = 11,
  parameter int ACC_W = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [DW-1:0]    x,
  input  logic signed [DW-1:0]    c,
  output logic signed [ACC_W-1:0] acc_next
);
  logic signed [2*DW-1:0]  prod;
  logic signed [2*DW-1:0]  prod_sh;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    prod     = x * c;
    prod_sh  = prod >>> SHIFT;
    term     = ACC_W'(prod_sh);
    acc_next = acc + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc_next;
  end
endmodule

// File: rtl/fir_out_stage.sv
// Round half-up by RND fraction bits, then clamp into DW-bit signed range.
module fir_out_stage #(
  parameter int ACC_W = 25,
  parameter int DW    = 16,
  parameter int RND   = 4
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [DW-1:0]    y
);
  localparam int HALF = 1 << (RND - 1);
  localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACC_W:0] MINV = -((ACC_W+1)'(2 ** (DW - 1)));

  logic signed [ACC_W:0] sum_r;
  logic signed [ACC_W:0] q;

  always_comb begin
    sum_r = $signed({acc[ACC_W-1], acc}) + $signed((ACC_W+1)'(HALF));
    q     = sum_r >>> RND;
    if (q > MAXV)      y = {1'b0, {(DW-1){1'b1}}};
    else if (q < MINV) y = {1'b1, {(DW-1){1'b0}}};
    else               y = DW'(q);
  end
endmodule

// File: rtl/fir_mac_ring.sv
module fir_mac_ring #(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int FRAC = 15,
  parameter int RND  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [DW-1:0]            s_data,
  input  logic                     coef_we,
  input  logic [$clog2(TAPS)-1:0]  coef_idx,
  input  logic [DW-1:0]            coef_data,
  output logic                     y_valid,
  output logic [DW-1:0]            y_data
);
  import fir_pkg::*;

  localparam int AW    = $clog2(TAPS);
  localparam int SHIFT = FRAC - RND;
  localparam int ACC_W = 2 * DW - SHIFT + AW + 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(TAPS - 1);
  localparam logic [AW-1:0] FIRST_C  = AW'(1 % TAPS);

  fir_state_e state, state_nxt;
  logic [AW-1:0] cnt, cnt_nxt;
  logic          accept, run, last;

  logic [AW-1:0] wp, wp_back, sptr, cptr;

  logic signed [DW-1:0] ring  [TAPS];
  logic signed [DW-1:0] coefs [TAPS];
  logic signed [DW-1:0] xop, xop_nxt, cop, cop_nxt;

  logic signed [ACC_W-1:0] acc_next;
  logic signed [DW-1:0]    y_round;
  logic [DW-1:0]           y_data_nxt;
  logic                    y_valid_nxt;

  assign s_ready = (state == ST_IDLE);
  assign accept  = s_valid && s_ready;
  assign run     = (state == ST_RUN);
  assign last    = run && (cnt == LAST_IDX);
  assign wp_back = (wp == '0) ? LAST_IDX : wp - 1'b1;

  // Write position: newest sample lands here, then it moves up.
  fir_mod_ptr #(.N(TAPS), .UP(1'b1)) u_wptr (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
    .step(accept), .ptr(wp)
  );

  // Sample read pointer: starts one behind the newest, walks backward.
  fir_mod_ptr #(.N(TAPS), .UP(1'b0)) u_sptr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(wp_back),
    .step(run), .ptr(sptr)
  );

  // Coefficient pointer: starts at tap 1, walks forward.
  fir_mod_ptr #(.N(TAPS), .UP(1'b1)) u_cptr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(FIRST_C),
    .step(run), .ptr(cptr)
  );

  fir_mac_unit #(.DW(DW), .SHIFT(SHIFT), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(run),
    .x(xop), .c(cop), .acc_next(acc_next)
  );

  fir_out_stage #(.ACC_W(ACC_W), .DW(DW), .RND(RND)) u_out (
    .acc(acc_next), .y(y_round)
  );

  // Next-state logic
  always_comb begin
    state_nxt   = state;
    cnt_nxt     = cnt;
    xop_nxt     = xop;
    cop_nxt     = cop;
    y_data_nxt  = y_data;
    y_valid_nxt = 1'b0;
    if (accept) begin
      state_nxt = ST_RUN;
      cnt_nxt   = '0;
      xop_nxt   = s_data;
      cop_nxt   = coefs[0];
    end else if (run) begin
      xop_nxt = ring[sptr];
      cop_nxt = coefs[cptr];
      cnt_nxt = cnt + 1'b1;
      if (last) begin
        state_nxt   = ST_IDLE;
        cnt_nxt     = '0;
        y_data_nxt  = y_round;
        y_valid_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      xop     <= '0;
      cop     <= '0;
      y_data  <= '0;
      y_valid <= 1'b0;
    end else begin
      state   <= state_nxt;
      cnt     <= cnt_nxt;
      xop     <= xop_nxt;
      cop     <= cop_nxt;
      y_data  <= y_data_nxt;
      y_valid <= y_valid_nxt;
    end
  end

  // Storage with explicit write enables
  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_store
      logic ring_en, coef_en;
      assign ring_en = accept && (wp == AW'(k));
      assign coef_en = coef_we && s_ready && (coef_idx == AW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ring[k]  <= '0;
          coefs[k] <= '0;
        end else begin
          if (ring_en) ring[k]  <= s_data;
          if (coef_en) coefs[k] <= coef_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fir_mac_ring_chk.sv
module fir_mac_ring_chk #(
  parameter int TAPS = 8,
  parameter int DW   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          y_valid,
  input logic [DW-1:0] y_data
);
  int unsigned left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 left <= 0;
    else if (s_valid && s_ready) left <= TAPS;
    else if (left != 0)          left <= left - 1;
  end

  // R2: busy right after an accepted sample
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R2: not ready while the loop window is open
  p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (left != 0) |-> !s_ready);

  // R3: result arrives exactly at the end of the window
  p_result_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (left == 1) |=> y_valid);

  p_result_only_when_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> ($past(left) == 1));

  p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  // R10: output word holds between pulses
  p_hold_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid |-> $stable(y_data));
endmodule

bind fir_mac_ring fir_mac_ring_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .y_valid(y_valid), .y_data(y_data)
);

// File: tb/fir_mac_ring_bench.sv
`timescale 1ns/1ps
module fir_mac_ring_bench;
  localparam int TAPS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_idx = '0;
  logic [15:0] coef_data = '0;
  logic        y_valid;
  logic [15:0] y_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic signed [15:0] hist [TAPS];
  logic signed [15:0] cf   [TAPS];

  always #5 clk = ~clk;

  fir_mac_ring u_fir_mac_ring (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .y_valid(y_valid), .y_data(y_data)
  );

  function automatic logic [15:0] model();
    longint acc = 0;
    for (int i = 0; i < TAPS; i++)
      acc += (longint'(hist[i]) * longint'(cf[i])) >>> 11;
    acc = (acc + 8) >>> 4;
    if (acc > 32767)  return 16'h7FFF;
    if (acc < -32768) return 16'h8000;
    return 16'(acc);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcoef(int idx, logic [15:0] v, bit model_upd);
    @(negedge clk);
    coef_we = 1'b1; coef_idx = 3'(idx); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    if (model_upd) cf[idx] = v;
  endtask

  // Sends one sample, checks timing and the result against the model.
  task automatic send(logic [15:0] x, string req, bit poke_coef);
    int lat;
    bit ready_ok;
    logic [15:0] exp;
    @(negedge clk);
    s_valid = 1'b1; s_data = x;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp = model();
    lat = 1;
    ready_ok = 1'b1;
    if (poke_coef) begin
      coef_we = 1'b1; coef_idx = 3'd0; coef_data = 16'h5A5A;
    end
    while (!y_valid && lat < 3 * TAPS) begin
      if (s_ready) ready_ok = 1'b0;
      @(negedge clk);
      coef_we = 1'b0;
      lat++;
    end
    chk("R2 ready low during loop", 32'(ready_ok), 32'd1);
    chk("R3 result latency", 32'(lat), 32'(TAPS + 1));
    chk(req, 32'(y_data), 32'(exp));
    @(negedge clk);
    chk("R3 single-cycle pulse", 32'(y_valid), 32'd0);
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h0000BEEF);
    for (int i = 0; i < TAPS; i++) begin hist[i] = '0; cf[i] = '0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 s_ready after reset", 32'(s_ready), 32'd1);
    chk("R9 y_valid after reset", 32'(y_valid), 32'd0);
    chk("R9 y_data after reset", 32'(y_data), 32'd0);
    rst_n = 1'b1;
    // R9: zero coefficients give zero output
    send(16'h7FFF, "R9 cleared coefficients", 1'b0);

    // R1: single tap of 0.5 halves the sample
    wcoef(0, 16'h4000, 1'b1);
    send(16'h2468, "R1 half gain", 1'b0);
    send(16'hC000, "R1 half gain negative", 1'b0);

    // R7: rounding boundaries with a0 = 2^11 (product passes through)
    wcoef(0, 16'h0800, 1'b1);
    for (int i = 0; i < TAPS; i++) send(16'h0000, "R7 flush", 1'b0);
    send(16'h0008, "R7 half step rounds up", 1'b0);
    send(16'h0007, "R7 below half rounds down", 1'b0);
    send(16'hFFF8, "R7 negative half step", 1'b0);
    send(16'hFFF7, "R7 negative beyond half", 1'b0);

    // R1 R4: random coefficients and a long random stream (store wraps)
    for (int i = 0; i < TAPS; i++) wcoef(i, 16'($urandom) >>> 2, 1'b1);
    for (int k = 0; k < 3 * TAPS; k++) send(16'($urandom), "R1 R4 random stream", 1'b0);

    // R4: only one tap nonzero at the last position; older samples drop out
    for (int i = 0; i < TAPS; i++) wcoef(i, (i == TAPS - 1) ? 16'h7FFF : 16'h0000, 1'b1);
    send(16'h4000, "R4 marker enters", 1'b0);
    for (int k = 0; k < TAPS - 1; k++) send(16'h0000, "R4 marker aging", 1'b0);
    send(16'h0000, "R4 marker evicted", 1'b0);

    // R5: positive clamp
    for (int i = 0; i < TAPS; i++) wcoef(i, 16'h7FFF, 1'b1);
    for (int k = 0; k < TAPS; k++) send(16'h7FFF, "R5 positive clamp", 1'b0);
    // R6: negative clamp
    for (int k = 0; k < TAPS; k++) send(16'h8000, "R6 negative clamp", 1'b0);
    for (int i = 0; i < TAPS; i++) wcoef(i, 16'h8000, 1'b1);
    send(16'h8000, "R5 min times min clamps high", 1'b0);

    // R8: coefficient write during the loop is ignored
    for (int i = 0; i < TAPS; i++) wcoef(i, 16'($urandom) >>> 3, 1'b1);
    send(16'h1234, "R8 write during loop ignored", 1'b1);
    send(16'h0F0F, "R8 table unchanged afterwards", 1'b0);

    // R10: output holds while idle
    begin
      logic [15:0] held;
      held = y_data;
      repeat (5) @(negedge clk);
      chk("R10 output hold", 32'(y_data), 32'(held));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule